// File: doc/BRIEF.md
# Manchester Sync Encoder

This block turns a serial NRZ bit stream into a pair of complementary Manchester II (biphase-L) line outputs. A single oversampling system clock drives it. The bit period is that clock divided by 16 or by 32, and a speed-select input chooses which. The block also drives a 1X bit clock. An external data source uses that clock to present NRZ bits, changing `nrz_in` on each rising edge. The encoder samples `nrz_in` when the bit clock falls, and each sampled bit goes out in the bit period that follows.

The `tx_block` input gates transmission. While it is high the line rests with both outputs high and the bit clock low. A high-to-low transition of `tx_block` starts a frame. The frame opens with a preamble of eight Manchester zeros, then a three-bit sync pulse that is high for 1.5 bit periods and low for 1.5 bit periods. After the sync, data is encoded continuously, with no parity or word framing, until `tx_block` returns high.

The controller is a five-state machine:
- `ST_IDLE` leaves on a start edge to `ST_PREAMBLE`.
- `ST_PREAMBLE` moves to `ST_SYNC` after its sixteenth half-bit.
- `ST_SYNC` moves to `ST_DATA` after its sixth half-bit.
- `ST_DATA` stays in `ST_DATA` at each bit end while transmission continues, or goes to `ST_FLUSH` at a bit end once a stop is pending.
- `ST_FLUSH` returns to `ST_IDLE` after one bit.
- A stop pending at a bit end in `ST_PREAMBLE` or `ST_SYNC` aborts straight to `ST_IDLE`.

Top module: `manchester_sync_encoder`

## Requirements
- R1: After reset, and whenever no frame is in progress, `line_pos` and `line_neg` are both 1 and `bit_clk` is 0. Holding `tx_block` low through reset release does not start a frame, because only a 1-to-0 transition of `tx_block` seen after reset starts one.
- R2: A half-bit lasts 8 system clocks when `speed_sel` is 0 and 16 when it is 1, so a bit period is 16 or 32 clocks.
- R3: `speed_sel` is captured only while the block is idle. A change of `speed_sel` during a frame does not alter that frame's waveform.
- R4: The first clock edge that sees `tx_block` low after it was high begins the preamble, and the line changes right after that edge. The preamble is 8 Manchester zeros, each with `line_pos` low in the first half and high in the second half.
- R5: The sync pulse follows the preamble. It spans 3 bit periods, with `line_pos` high for the first 3 half-bits and low for the next 3.
- R6: Data bit value 1 drives `line_pos` high then low. Data bit value 0 drives `line_pos` low then high. During any frame `line_neg` is the complement of `line_pos`.
- R7: `bit_clk` is high during the first half of the third sync bit and during the first half of every data bit except the last. Its first rise is 20 half-bits after the start edge. The value of `nrz_in` at each falling edge of `bit_clk` is the bit encoded in the next bit period.
- R8: Once `tx_block` is seen high during the data phase, the current bit completes, one further bit (the one already sampled) is sent, and then the line returns to idle. `bit_clk` is 0 in every cycle after a cycle in which `tx_block` was high.
- R9: If `tx_block` goes high during the preamble or the sync, the line returns to idle at the end of the bit period in progress. No data bit is sent and `bit_clk` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| speed_sel | input | 1 | 0: 16 clocks per bit, 1: 32 clocks per bit |
| tx_block | input | 1 | High holds the line idle; a falling edge starts a frame |
| nrz_in | input | 1 | Serial NRZ data, sampled on the falling edge of bit_clk |
| bit_clk | output | 1 | 1X bit clock for the data source |
| line_pos | output | 1 | Manchester output, high first for a 1 |
| line_neg | output | 1 | Complement of line_pos while a frame is active |

## Verification
The assertions assume that `tx_block`, `speed_sel` and `nrz_in` are synchronous to `clk` and change only between its rising edges. They also assume the data source holds `nrz_in` steady across each falling edge of `bit_clk`. The stimulus changes every input on the falling edge of `clk`, and it updates `nrz_in` only in the cycle after it sees `bit_clk` rise, so the value is settled well before the sampling edge half a bit later. Raise and abort points are placed in the middle of a half-bit, so the expected end-of-frame bit is never ambiguous.

// File: rtl/mse_pkg.sv
package mse_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_SYNC,
        ST_DATA,
        ST_FLUSH
    } mse_state_t;

    // Sync pulse: six half-bits, high for the first three.
    localparam int SYNC_HALVES    = 6;
    localparam int SYNC_HI_HALVES = 3;
    // Half-bit of the sync in which the bit clock first runs.
    localparam int SYNC_CLK_HALF  = 4;

endpackage

// File: rtl/mse_half_timer.sv
module mse_half_timer #(
    parameter int FAST_HALF = 8,
    parameter int SLOW_HALF = 16,
    parameter int CW        = $clog2(SLOW_HALF)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          speed_sel,
    input  logic          cfg_open,
    input  logic          run,
    output logic          slow_q,
    output logic [CW-1:0] half_cnt,
    output logic          half_end
);

    logic [CW-1:0] last_cnt;

    assign last_cnt = slow_q ? CW'(SLOW_HALF - 1) : CW'(FAST_HALF - 1);
    assign half_end = run && (half_cnt == last_cnt);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slow_q   <= 1'b0;
            half_cnt <= '0;
        end else begin
            if (cfg_open) begin
                slow_q <= speed_sel;
            end
            if (!run || half_end) begin
                half_cnt <= '0;
            end else begin
                half_cnt <= half_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/mse_seq_fsm.sv
module mse_seq_fsm
    import mse_pkg::*;
#(
    parameter int PRE_BITS = 8,
    parameter int SW       = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_block,
    input  logic          nrz_in,
    input  logic          half_end,
    output mse_state_t    state,
    output logic [SW-1:0] seq,
    output logic          data_cur,
    output logic          stop_req,
    output logic          start
);

    localparam int PRE_LAST  = 2 * PRE_BITS - 1;
    localparam int SYNC_LAST = SYNC_HALVES - 1;

    mse_state_t    state_n;
    logic [SW-1:0] seq_n;
    logic          blk_q;
    logic          data_nxt;
    logic          bit_end;
    logic          sample_now;
    logic          load_cur;

    assign start   = (state == ST_IDLE) && blk_q && !tx_block;
    assign bit_end = half_end && seq[0];

    assign sample_now = half_end &&
        (((state == ST_SYNC) && (seq == SW'(SYNC_CLK_HALF))) ||
         ((state == ST_DATA) && !seq[0]));
    assign load_cur = bit_end &&
        (((state == ST_SYNC) && (seq == SW'(SYNC_LAST))) ||
         (state == ST_DATA));

    // Next-state process
    always_comb begin
        state_n = state;
        seq_n   = seq;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    state_n = ST_PREAMBLE;
                    seq_n   = '0;
                end
            end
            ST_PREAMBLE: begin
                if (half_end) begin
                    if (bit_end && stop_req) begin
                        state_n = ST_IDLE;
                        seq_n   = '0;
                    end else if (seq == SW'(PRE_LAST)) begin
                        state_n = ST_SYNC;
                        seq_n   = '0;
                    end else begin
                        seq_n = seq + 1'b1;
                    end
                end
            end
            ST_SYNC: begin
                if (half_end) begin
                    if (bit_end && stop_req) begin
                        state_n = ST_IDLE;
                        seq_n   = '0;
                    end else if (seq == SW'(SYNC_LAST)) begin
                        state_n = ST_DATA;
                        seq_n   = '0;
                    end else begin
                        seq_n = seq + 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (half_end) begin
                    if (seq[0]) begin
                        state_n = stop_req ? ST_FLUSH : ST_DATA;
                        seq_n   = '0;
                    end else begin
                        seq_n = SW'(1);
                    end
                end
            end
            ST_FLUSH: begin
                if (half_end) begin
                    if (seq[0]) begin
                        state_n = ST_IDLE;
                        seq_n   = '0;
                    end else begin
                        seq_n = SW'(1);
                    end
                end
            end
            default: begin
                state_n = ST_IDLE;
                seq_n   = '0;
            end
        endcase
    end

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            seq      <= '0;
            blk_q    <= 1'b0;
            stop_req <= 1'b0;
            data_nxt <= 1'b0;
            data_cur <= 1'b0;
        end else begin
            state    <= state_n;
            seq      <= seq_n;
            blk_q    <= tx_block;
            stop_req <= (state_n != ST_IDLE) && (stop_req || tx_block);
            if (sample_now) begin
                data_nxt <= nrz_in;
            end
            if (load_cur) begin
                data_cur <= data_nxt;
            end
        end
    end

endmodule

// File: rtl/mse_line_drive.sv
module mse_line_drive
    import mse_pkg::*;
#(
    parameter int SW = 4
) (
    input  mse_state_t    state,
    input  logic [SW-1:0] seq,
    input  logic          data_cur,
    input  logic          stop_req,
    output logic          line_pos,
    output logic          line_neg,
    output logic          bit_clk
);

    // Output process
    always_comb begin
        line_pos = 1'b1;
        line_neg = 1'b1;
        bit_clk  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                line_pos = 1'b1;
                line_neg = 1'b1;
            end
            ST_PREAMBLE: begin
                line_pos = seq[0];
                line_neg = !seq[0];
            end
            ST_SYNC: begin
                line_pos = (seq < SW'(SYNC_HI_HALVES));
                line_neg = !line_pos;
                bit_clk  = (seq == SW'(SYNC_CLK_HALF)) && !stop_req;
            end
            ST_DATA: begin
                line_pos = data_cur ^ seq[0];
                line_neg = !line_pos;
                bit_clk  = !seq[0] && !stop_req;
            end
            ST_FLUSH: begin
                line_pos = data_cur ^ seq[0];
                line_neg = !line_pos;
            end
            default: begin
                line_pos = 1'b1;
                line_neg = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/manchester_sync_encoder.sv
module manchester_sync_encoder
    import mse_pkg::*;
#(
    parameter int BIT_CYC_FAST = 16,
    parameter int BIT_CYC_SLOW = 32,
    parameter int PRE_BITS     = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic speed_sel,
    input  logic tx_block,
    input  logic nrz_in,
    output logic bit_clk,
    output logic line_pos,
    output logic line_neg
);

    localparam int FAST_HALF = BIT_CYC_FAST / 2;
    localparam int SLOW_HALF = BIT_CYC_SLOW / 2;
    localparam int CW        = $clog2(SLOW_HALF);
    localparam int MAX_SEQ   = (2 * PRE_BITS > SYNC_HALVES) ? 2 * PRE_BITS : SYNC_HALVES;
    localparam int SW        = $clog2(MAX_SEQ);

    mse_state_t    state;
    logic [SW-1:0] seq;
    logic          data_cur;
    logic          stop_req;
    logic          start;
    logic          slow_q;
    logic [CW-1:0] half_cnt;
    logic          half_end;

    mse_half_timer #(
        .FAST_HALF (FAST_HALF),
        .SLOW_HALF (SLOW_HALF),
        .CW        (CW)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .speed_sel (speed_sel),
        .cfg_open  ((state == ST_IDLE) && !start),
        .run       (state != ST_IDLE),
        .slow_q    (slow_q),
        .half_cnt  (half_cnt),
        .half_end  (half_end)
    );

    mse_seq_fsm #(
        .PRE_BITS (PRE_BITS),
        .SW       (SW)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_block (tx_block),
        .nrz_in   (nrz_in),
        .half_end (half_end),
        .state    (state),
        .seq      (seq),
        .data_cur (data_cur),
        .stop_req (stop_req),
        .start    (start)
    );

    mse_line_drive #(
        .SW (SW)
    ) u_drive (
        .state    (state),
        .seq      (seq),
        .data_cur (data_cur),
        .stop_req (stop_req),
        .line_pos (line_pos),
        .line_neg (line_neg),
        .bit_clk  (bit_clk)
    );

endmodule

// File: rtl/mse_checker.sv
module mse_checker
    import mse_pkg::*;
#(
    parameter int FAST_HALF = 8,
    parameter int SLOW_HALF = 16,
    parameter int CW        = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tx_block,
    input logic          bit_clk,
    input logic          line_pos,
    input logic          line_neg,
    input mse_state_t    state,
    input logic          slow_q,
    input logic [CW-1:0] half_cnt
);

    assert_idle_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (line_pos && line_neg && !bit_clk));

    assert_half_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(half_cnt) < (slow_q ? SLOW_HALF : FAST_HALF)));

    assert_speed_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> $stable(slow_q));

    assert_start_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((state != ST_IDLE) && ($past(state) == ST_IDLE)) |-> (!$past(tx_block) && !line_pos));

    assert_complement_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> (line_pos != line_neg));

    assert_clk_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_block |=> !bit_clk);

endmodule

bind manchester_sync_encoder mse_checker #(
    .FAST_HALF (FAST_HALF),
    .SLOW_HALF (SLOW_HALF),
    .CW        (CW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_block (tx_block),
    .bit_clk  (bit_clk),
    .line_pos (line_pos),
    .line_neg (line_neg),
    .state    (state),
    .slow_q   (slow_q),
    .half_cnt (half_cnt)
);

// File: tb/manchester_sync_encoder_tb.sv
`timescale 1ns/1ps
module manchester_sync_encoder_tb;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n;
    logic speed_sel;
    logic tx_block;
    logic nrz_in;
    logic bit_clk;
    logic line_pos;
    logic line_neg;

    int checks   = 0;
    int failures = 0;

    logic lp_a [0:4095];
    logic ln_a [0:4095];
    logic bc_a [0:4095];

    manchester_sync_encoder u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .speed_sel (speed_sel),
        .tx_block  (tx_block),
        .nrz_in    (nrz_in),
        .bit_clk   (bit_clk),
        .line_pos  (line_pos),
        .line_neg  (line_neg)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Expected {line_pos, line_neg, bit_clk} at sample k after the start edge.
    function automatic logic [2:0] expv(input int k, input int h, input int n,
                                        input logic [63:0] pat, input int end_k);
        int   half;
        int   j;
        logic lp;
        logic bc;
        half = k / h;
        bc   = 1'b0;
        if (k >= end_k) return 3'b110;
        if (half < 16) begin
            lp = half[0];
        end else if (half < 22) begin
            lp = (half - 16) < 3;
            bc = (half == 20);
        end else begin
            j  = (half - 22) / 2;
            lp = pat[j] ^ half[0];
            bc = !half[0] && (j <= n - 2);
        end
        return {lp, !lp, bc};
    endfunction

    task automatic capture(input bit spd, input int total, input int stop_k,
                           input int flip_k, input logic [63:0] pat, output int feed);
        @(negedge clk);
        speed_sel = spd;
        tx_block  = 1'b1;
        nrz_in    = 1'b0;
        repeat (4) @(negedge clk);
        tx_block = 1'b0;
        feed     = 0;
        for (int k = 0; k < total; k++) begin
            @(negedge clk);
            lp_a[k] = line_pos;
            ln_a[k] = line_neg;
            bc_a[k] = bit_clk;
            if (bit_clk && (k == 0 || !bc_a[k-1])) begin
                if (feed < 64) nrz_in = pat[feed];
                feed++;
            end
            if (k == stop_k) tx_block = 1'b1;
            if (k == flip_k) speed_sel = !spd;
        end
    endtask

    task automatic compare(input int total, input int h, input int n,
                           input logic [63:0] pat, input int end_k, input string tag);
        int bad [5];
        int fa  [5];
        int fe  [5];
        int rg;
        logic [2:0] e;
        for (int i = 0; i < 5; i++) begin bad[i] = 0; fa[i] = 0; fe[i] = 0; end
        for (int k = 0; k < total; k++) begin
            e  = expv(k, h, n, pat, end_k);
            rg = (k >= end_k) ? 3 : ((k / h) < 16) ? 0 : ((k / h) < 22) ? 1 : 2;
            if ({lp_a[k], ln_a[k]} != e[2:1]) begin
                if (bad[rg] == 0) begin fa[rg] = int'({lp_a[k], ln_a[k]}); fe[rg] = int'(e[2:1]); end
                bad[rg]++;
            end
            if (bc_a[k] != e[0]) begin
                if (bad[4] == 0) begin fa[4] = int'(bc_a[k]); fe[4] = int'(e[0]); end
                bad[4]++;
            end
        end
        check(bad[0] == 0, "R4", {tag, " preamble lines"}, fa[0], fe[0]);
        check(bad[1] == 0, "R5", {tag, " sync lines"}, fa[1], fe[1]);
        check(bad[2] == 0, "R6", {tag, " data lines"}, fa[2], fe[2]);
        check(bad[3] == 0, "R8", {tag, " idle after stop"}, fa[3], fe[3]);
        check(bad[4] == 0, "R7", {tag, " bit clock waveform"}, fa[4], fe[4]);
    endtask

    task automatic run_frame(input bit spd, input int n, input logic [63:0] pat,
                             input bit flip, input string tag);
        int h;
        int end_k;
        int total;
        int feed;
        h     = spd ? 16 : 8;
        end_k = (22 + 2 * n) * h;
        total = end_k + 2 * h;
        capture(spd, total, (23 + 2 * (n - 2)) * h + 1, flip ? 3 * h : -1, pat, feed);
        compare(total, h, n, pat, end_k, tag);
        check(feed == n, "R7", {tag, " bits requested by bit_clk"}, feed, n);
        check(lp_a[19*h-1] == 1'b1 && lp_a[19*h] == 1'b0, "R2",
              {tag, " sync fall at half-bit 19"}, int'(lp_a[19*h]), 0);
        check(bc_a[20*h-1] == 1'b0 && bc_a[20*h] == 1'b1, "R7",
              {tag, " first bit_clk rise at half-bit 20"}, int'(bc_a[20*h]), 1);
        if (flip) check(lp_a[3*h+2] == 1'b1 && lp_a[4*h] == 1'b0, "R3",
                        {tag, " speed change ignored mid-frame"}, int'(lp_a[4*h]), 0);
    endtask

    task automatic run_abort(input bit spd, input int abort_k, input int end_k,
                             input string tag);
        int h;
        int feed;
        h = spd ? 16 : 8;
        capture(spd, end_k + 4 * h, abort_k, -1, 64'd0, feed);
        compare(end_k + 4 * h, h, 0, 64'd0, end_k, tag);
        check(feed == 0, "R9", {tag, " no bit_clk after abort"}, feed, 0);
        check(lp_a[end_k-1] == 1'b1 && lp_a[end_k] && ln_a[end_k], "R9",
              {tag, " idle at bit end"}, int'({lp_a[end_k], ln_a[end_k]}), 3);
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog: actual=%0d expected=%0d", checks, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int bad;
        rst_n     = 1'b0;
        tx_block  = 1'b0;
        speed_sel = 1'b0;
        nrz_in    = 1'b0;
        repeat (5) @(negedge clk);
        check(line_pos && line_neg && !bit_clk, "R1", "lines in reset",
              int'({line_pos, line_neg, bit_clk}), 6);
        rst_n = 1'b1;
        bad   = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (!(line_pos && line_neg && !bit_clk)) bad++;
        end
        check(bad == 0, "R1", "no start without falling edge", bad, 0);

        for (int s = 0; s < 2; s++) begin
            for (int p = 0; p < 16; p++) begin
                run_frame(s[0], 4, 64'(p), 1'b0, "sweep4");
            end
        end
        run_frame(1'b0, 2, 64'h2, 1'b0, "short_fast");
        run_frame(1'b1, 2, 64'h1, 1'b0, "short_slow");
        run_frame(1'b0, 16, 64'hA5C3, 1'b0, "mix_fast");
        run_frame(1'b1, 16, 64'h3C5A, 1'b0, "mix_slow");
        run_frame(1'b0, 24, 64'h555555, 1'b0, "alt_fast");
        run_frame(1'b1, 9, 64'h1FF, 1'b0, "ones_slow");
        run_frame(1'b0, 8, 64'h00, 1'b1, "flip_fast_r3");
        run_frame(1'b1, 12, 64'hB6D, 1'b1, "flip_slow_r3");

        run_abort(1'b0, 5 * 8 + 3, 6 * 8, "abort_pre_r9");
        run_abort(1'b0, 2, 2 * 8, "abort_first_r9");
        run_abort(1'b1, 17 * 16 + 5, 18 * 16, "abort_sync_r9");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule